// File: doc/BRIEF.md
# Peripheral Receive DMA Channel

This block sits beside a serial protocol decoder and moves each received byte into a memory or register-file space, without help from the processor. The decoder pulses a ready strobe when a new byte is in its receive data register. The channel then raises a request toward a priority arbiter. Once granted, it writes that byte at its current address pointer, advances the pointer and counts one transfer off its transaction counter.

Software loads a 16-bit start address and an 8-bit transfer count while the channel is disabled, then sets the enable bit. When the counter reaches zero, the channel raises an end-of-block pending bit and drops its own enable. That bit stays set until software writes a 1 to clear it. Software can also stop the channel at any time by clearing the enable bit.

Top module: `rx_dma_channel`

## Requirements
- R1: `dma_req` is high only while the ready flag is 1, the enable bit is 1 and the counter is nonzero. No request is raised when any of these is 0.
- R2: A memory write happens only after a grant. `mem_we` is high for exactly the one cycle that follows a cycle in which both `dma_req` and `dma_gnt` were high. During that cycle, `mem_addr` equals the pointer and `mem_wdata` equals `rx_data` as sampled in the grant cycle. A withheld grant holds the request with no write.
- R3: On the edge that ends a write cycle, the pointer increments by 1, wrapping from 16'hFFFF to 16'h0000, and the counter decrements by 1.
- R4: The ready flag clears on the edge that ends a write cycle. A `rdy_set` strobe on that same edge wins, and the flag stays 1.
- R5: When a write completes with the counter at 1, `eob_pend` becomes 1 and `dma_en` becomes 0 on that edge.
- R6: `eob_pend` holds its value until `pend_clr` is pulsed. A completion on the same edge takes priority over the clear.
- R7: Pulsing `en_clr` drops a pending request from the next cycle on, and no write follows unless the grant arrived before the clear took effect.
- R8: `ld_addr` and `ld_cnt` load `cfg_wdata` only while `dma_en` is 0. While enabled, they are ignored.
- R9: At most one transfer is in flight. A `rdy_set` that arrives during a transfer is serviced by a separate transfer after that transfer completes.
- R10: After reset, the pointer, counter, ready flag, enable, pending bit, `dma_req` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_set | input | 1 | Decoder strobe: a new byte is in the receive register |
| rx_data | input | 8 | Decoder receive data register |
| ld_addr | input | 1 | Load pointer from cfg_wdata (only while disabled) |
| ld_cnt | input | 1 | Load counter from cfg_wdata[7:0] (only while disabled) |
| en_set | input | 1 | Set the enable bit |
| en_clr | input | 1 | Clear the enable bit |
| pend_clr | input | 1 | Write-1 clear of the end-of-block pending bit |
| cfg_wdata | input | 16 | Load value for pointer and counter |
| dma_gnt | input | 1 | Grant from the priority arbiter |
| dma_req | output | 1 | Request to the priority arbiter |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rdy_flag | output | 1 | Receive-data-ready flag |
| dma_en | output | 1 | Enable bit |
| eob_pend | output | 1 | End-of-block pending bit |
| cur_addr | output | 16 | Current address pointer |
| cur_cnt | output | 8 | Transfers still to be done |

## Verification
The hardest case to reach is a new ready strobe that lands on the exact edge where a write finishes. At that edge, the clear and the set of the ready flag collide.

To reach it, the stimulus watches `mem_we` at the falling edge and raises `rdy_set` with a fresh byte in that same half cycle. The scoreboard then expects a second, separate write.

A second hard case is a software stop while a request waits on a withheld grant. The arbiter model holds back its grant, which leaves the request pending long enough to clear the enable bit under it.

// File: rtl/rx_dma_pkg.sv
// Package rx_dma_pkg
// Holds the types shared by the receive DMA channel: the transfer
// sequencer state encoding. Assumes nothing beyond IEEE 1800-2017.
package rx_dma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,   // no transfer in flight
        XS_WAIT = 2'd1,   // request raised, waiting for the arbiter
        XS_XFER = 2'd2    // memory write cycle
    } xfer_state_t;

endpackage

// File: rtl/rx_dma_flags.sv
// Module rx_dma_flags
// Keeps the three one-bit control flags of the channel: the
// receive-data-ready flag, the enable bit and the end-of-block pending
// bit. Assumes `done` is high for exactly the cycle whose closing edge
// completes a write, and that `last` is valid in that cycle.
module rx_dma_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_set,
    input  logic en_set,
    input  logic en_clr,
    input  logic pend_clr,
    input  logic done,
    input  logic last,
    output logic rdy_q,
    output logic en_q,
    output logic pend_q
);

    // Ready flag: the hardware set wins over the completion clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q <= 1'b0;
        else if (rdy_set) rdy_q <= 1'b1;
        else if (done)    rdy_q <= 1'b0;
    end

    // Enable bit: the end-of-block auto-clear beats any software action.
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= 1'b0;
        else if (done && last)  en_q <= 1'b0;
        else if (en_clr)        en_q <= 1'b0;
        else if (en_set)        en_q <= 1'b1;
    end

    // Pending bit: set by the last completion, cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)             pend_q <= 1'b0;
        else if (done && last)  pend_q <= 1'b1;
        else if (pend_clr)      pend_q <= 1'b0;
    end

    AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rdy_set) |=> !rdy_q); // R4
    AST_EOB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && last) |=> (pend_q && !en_q)); // R5
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pend_clr) |=> pend_q); // R6

endmodule

// File: rtl/rx_dma_ptr.sv
// Module rx_dma_ptr
// Address pointer and transaction counter. Both load from the software
// value only while the channel is disabled. On each completed write, the
// pointer post-increments (wrapping modulo 2**ADDR_W) and the counter
// post-decrements. Assumes `done` is never high with a zero counter.
module rx_dma_ptr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              done,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              cnt_nz,
    output logic              last
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // Pointer: a software load while disabled, otherwise a step per write.
    always_ff @(posedge clk) begin
        if (!rst_n)              addr_q <= '0;
        else if (done)           addr_q <= addr_q + ADDR_ONE;
        else if (ld_addr && !en) addr_q <= wdata;
    end

    // Counter: a software load while disabled, otherwise a step down per write.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (done)          cnt_q <= cnt_q - CNT_ONE;
        else if (ld_cnt && !en) cnt_q <= wdata[CNT_W-1:0];
    end

    // Status of the counter as seen by the sequencer and the flags.
    always_comb begin
        cnt_nz = (cnt_q != '0);
        last   = (cnt_q == CNT_ONE);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (addr_q == $past(addr_q) + ADDR_ONE)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R3
    AST_LOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !done) |=> ($stable(addr_q) && $stable(cnt_q))); // R8

endmodule

// File: rtl/rx_dma_ctrl.sv
// Module rx_dma_ctrl
// Transfer sequencer. It raises one request at a time toward the
// arbiter, captures the receive byte in the grant cycle, and drives a
// single write cycle. Assumes the arbiter grants only while the request
// is high, and that the grant lasts one cycle.
module rx_dma_ctrl
    import rx_dma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy,
    input  logic              en,
    input  logic              cnt_nz,
    input  logic              gnt,
    input  logic [DATA_W-1:0] rx_data,
    output logic              req,
    output logic              done,
    output logic [DATA_W-1:0] data_q
);

    xfer_state_t state_q, state_d;
    logic        take;

    // Next-state and grant acceptance.
    always_comb begin
        take    = (state_q == XS_WAIT) && en && gnt;
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (rdy && en && cnt_nz) state_d = XS_WAIT;
            XS_WAIT: if (!en)                 state_d = XS_IDLE;
                     else if (gnt)            state_d = XS_XFER;
            XS_XFER:                          state_d = XS_IDLE;
            default:                          state_d = XS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Byte capture at the grant so a later decoder update cannot corrupt it.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (take) data_q <= rx_data;
    end

    // Outward strobes decoded from the state.
    always_comb begin
        req  = (state_q == XS_WAIT) && en;
        done = (state_q == XS_XFER);
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (en && cnt_nz)); // R1
    AST_WE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req && gnt)); // R2
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_NO_REQ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req); // R9

endmodule

// File: rtl/rx_dma_channel.sv
// Module rx_dma_channel
// Top of the receive DMA channel. It joins the flag register, the
// pointer/counter pair and the transfer sequencer, and presents a
// single-port memory write interface. Assumes a synchronous active-low
// reset, and that rx_data stays valid from rdy_set until the grant.
module rx_dma_channel #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_set,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              pend_clr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dma_gnt,
    output logic              dma_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rdy_flag,
    output logic              dma_en,
    output logic              eob_pend,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt
);

    logic              done;
    logic              last;
    logic              cnt_nz;
    logic [DATA_W-1:0] data_q;

    rx_dma_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdy_set  (rdy_set),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pend_clr (pend_clr),
        .done     (done),
        .last     (last),
        .rdy_q    (rdy_flag),
        .en_q     (dma_en),
        .pend_q   (eob_pend)
    );

    rx_dma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (dma_en),
        .ld_addr (ld_addr),
        .ld_cnt  (ld_cnt),
        .wdata   (cfg_wdata),
        .done    (done),
        .addr_q  (cur_addr),
        .cnt_q   (cur_cnt),
        .cnt_nz  (cnt_nz),
        .last    (last)
    );

    rx_dma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy     (rdy_flag),
        .en      (dma_en),
        .cnt_nz  (cnt_nz),
        .gnt     (dma_gnt),
        .rx_data (rx_data),
        .req     (dma_req),
        .done    (done),
        .data_q  (data_q)
    );

    // Memory write port driven from the sequencer and the pointer.
    always_comb begin
        mem_we    = done;
        mem_addr  = cur_addr;
        mem_wdata = data_q;
    end

    AST_STOP_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req); // R7
    AST_REQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> rdy_flag); // R1

endmodule

// File: tb/rx_dma_channel_bench.sv
module rx_dma_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy_set = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        ld_addr = 1'b0, ld_cnt = 1'b0, en_set = 1'b0, en_clr = 1'b0, pend_clr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        dma_gnt = 1'b0;
    logic        dma_req, mem_we, rdy_flag, dma_en, eob_pend;
    logic [15:0] mem_addr, cur_addr;
    logic [7:0]  mem_wdata, cur_cnt;

    int checks = 0, fails = 0, writes = 0;
    int gnt_delay = 0, wcnt = 0;
    bit gnt_block = 1'b0;
    logic [23:0] exp_q[$];
    logic [15:0] m_addr;

    always #5 clk = ~clk;

    rx_dma_channel u_rx_dma_channel (
        .clk(clk), .rst_n(rst_n), .rdy_set(rdy_set), .rx_data(rx_data),
        .ld_addr(ld_addr), .ld_cnt(ld_cnt), .en_set(en_set), .en_clr(en_clr),
        .pend_clr(pend_clr), .cfg_wdata(cfg_wdata), .dma_gnt(dma_gnt),
        .dma_req(dma_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rdy_flag(rdy_flag), .dma_en(dma_en),
        .eob_pend(eob_pend), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arbiter model: grants after gnt_delay waiting cycles unless blocked.
    always @(negedge clk) begin
        if (dma_req && !dma_gnt && !gnt_block) begin
            if (wcnt >= gnt_delay) begin dma_gnt <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
        end else begin
            dma_gnt <= 1'b0;
            if (!dma_req) wcnt <= 0;
        end
    end

    // Monitor: pops the expected write and compares (R2).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            writes++;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk("R2 write addr/data", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
            end
        end
    end

    task automatic pulse_cfg(input int which, input logic [15:0] v);
        @(negedge clk);
        cfg_wdata = v;
        case (which)
            0: ld_addr = 1'b1;
            1: ld_cnt = 1'b1;
            2: en_set = 1'b1;
            3: en_clr = 1'b1;
            default: pend_clr = 1'b1;
        endcase
        @(negedge clk);
        {ld_addr, ld_cnt, en_set, en_clr, pend_clr} = '0;
    endtask

    // Driver: presents a byte and records the expected write.
    task automatic push_byte(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rdy_set = 1'b1;
        exp_q.push_back({m_addr, d});
        m_addr = m_addr + 16'd1;
        @(negedge clk);
        rdy_set = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (rdy_flag || dma_req || mem_we);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 addr", cur_addr, 0); chk("R10 cnt", cur_cnt, 0);
        chk("R10 flags", {rdy_flag, dma_en, eob_pend, dma_req, mem_we}, 0);

        // Configure and run three transfers with varied grant delays
        pulse_cfg(0, 16'h1000); pulse_cfg(1, 16'd3); pulse_cfg(2, 0);
        m_addr = 16'h1000;
        chk("R8 load while disabled", {cur_addr, cur_cnt}, {16'h1000, 8'd3});
        pulse_cfg(0, 16'h2222);
        chk("R8 load ignored while enabled", cur_addr, 16'h1000);
        gnt_delay = 0; push_byte(8'hA5); wait_idle();
        chk("R3 addr step", cur_addr, 16'h1001); chk("R3 cnt step", cur_cnt, 2);
        chk("R4 ready cleared", rdy_flag, 0);
        gnt_delay = 4; push_byte(8'h3C); wait_idle();
        chk("R3 cnt step 2", cur_cnt, 1);
        chk("R5 not yet pending", eob_pend, 0);
        gnt_delay = 1; push_byte(8'h7E); wait_idle();
        chk("R5 pending set", eob_pend, 1); chk("R5 enable cleared", dma_en, 0);
        chk("R3 counter zero", cur_cnt, 0);

        // R1: ready without enable raises no request
        @(negedge clk); rdy_set = 1'b1; rx_data = 8'h11;
        @(negedge clk); rdy_set = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 no request while disabled", dma_req, 0);
        chk("R6 pending holds", eob_pend, 1);
        pulse_cfg(4, 0);
        chk("R6 pending cleared", eob_pend, 0);

        // R1: enabled with zero count raises no request
        pulse_cfg(2, 0); repeat (3) @(negedge clk);
        chk("R1 no request at zero count", dma_req, 0);
        pulse_cfg(3, 0);

        // Address wrap and in-flight ready (R3, R9)
        pulse_cfg(0, 16'hFFFF); pulse_cfg(1, 16'd5); pulse_cfg(2, 0);
        m_addr = 16'hFFFF;
        // Stale flag from the R1 step is still set: expect one write of 8'h11
        exp_q.push_back({m_addr, 8'h11}); m_addr = m_addr + 16'd1;
        gnt_delay = 0; wait_idle();
        chk("R3 address wrap", cur_addr, 16'h0000);
        push_byte(8'h5A);
        do @(negedge clk); while (!mem_we);
        rx_data = 8'hC3; rdy_set = 1'b1;
        exp_q.push_back({m_addr, 8'hC3}); m_addr = m_addr + 16'd1;
        @(negedge clk); rdy_set = 1'b0;
        chk("R4 set wins over clear", rdy_flag, 1);
        wait_idle();
        chk("R9 second transfer done", {cur_addr, cur_cnt}, {16'h0002, 8'd2});

        // R2 withheld grant, then R7 software stop under a pending request
        gnt_block = 1'b1;
        @(negedge clk); rx_data = 8'h99; rdy_set = 1'b1;
        @(negedge clk); rdy_set = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 request held without grant", {dma_req, mem_we}, 2'b10);
        begin
            int w0;
            w0 = writes;
            pulse_cfg(3, 0);
            chk("R7 request dropped", dma_req, 0);
            gnt_block = 1'b0;
            repeat (6) @(negedge clk);
            chk("R7 no write after stop", writes, w0);
            chk("R7 pointer unchanged", cur_addr, 16'h0002);
        end
        chk("R2 scoreboard drained", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule